// File: doc/BRIEF.md
# Nonvolatile Store Sequencer with Busy Status

This block sits between the register bank of a dual digitally-controlled potentiometer and its bank of nonvolatile data registers. It takes store requests (a host write of a data byte, a copy of one pot's wiper position into one of its data registers, or a copy of every pot's wiper into the same-numbered register of each pot). It applies the hardware write-protect rule, and it runs a busy window of a configurable number of clock cycles for each accepted store.

While the window runs, a write-in-progress bit is high and is presented to the serial front end as a status byte. A parameter selects whether the data registers take the new value at the first cycle of the window or at the cycle the window closes. Requests that arrive while a store is running are dropped and recorded in a sticky flag. Wiper loads and stepping are handled elsewhere and never reach this block, so they never raise the busy bit.

Top module: `nvs_store_seq`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), busy is 0, status_byte is 8'h00, every data register reads 0, and the accept, blocked and reject outputs are 0.
- R2: A store request that is accepted (req_valid high, kind not 3, wp_n high, busy low) makes busy high from the next cycle. Busy stays high for exactly BUSY_CYCLES consecutive cycles.
- R3: Kind 0 (host write) stores req_data into data register req_reg of pot req_pot. Every other register keeps its value.
- R4: Kind 1 (single copy) stores the wiper value of pot req_pot, as sampled in the request cycle, into register req_reg of that pot. Later wiper changes have no effect on it.
- R5: Kind 2 (global copy) stores, within one busy window, each pot's wiper value into register req_reg of that same pot.
- R6: When wp_n is low, a store request is not performed: busy stays 0, no register changes, and store_blocked pulses high for one cycle in the next cycle.
- R7: A store request that arrives while busy is high is dropped. No register changes, the running window keeps its length, and reject_seen becomes 1 and stays 1 until reset.
- R8: With COMMIT_AT_END=1 the registers take the new value in the cycle busy falls, and still read the old value while busy is high. With COMMIT_AT_END=0 they take it in the first busy cycle.
- R9: status_byte equals 7 zero bits above the busy bit: bit 0 is busy and bits 7..1 are 0.
- R10: store_accepted pulses high for exactly one cycle, in the cycle after an accepted request, and coincides with the rise of busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, low blocks all stores |
| req_valid | input | 1 | Store request strobe, one cycle |
| req_kind | input | 2 | 0 host write, 1 single copy, 2 global copy, 3 ignored |
| req_pot | input | PW | Pot selector (unused for global copy) |
| req_reg | input | RW | Data register selector |
| req_data | input | W | Byte for host write |
| wiper_flat | input | NPOT*W | Current wiper positions, pot p at bits [p*W +: W] |
| rd_pot | input | PW | Read-port pot selector |
| rd_reg | input | RW | Read-port register selector |
| rd_data | output | W | Contents of the selected data register |
| busy | output | 1 | Write-in-progress bit |
| status_byte | output | 8 | Status byte for the status read command |
| store_accepted | output | 1 | One-cycle pulse for an accepted store |
| store_blocked | output | 1 | One-cycle pulse for a store stopped by write protect |
| reject_seen | output | 1 | Sticky flag for a request dropped while busy |

## Verification
The bench counts busy cycles at each store and compares the count with BUSY_CYCLES. A timer that is off by one would make a window one cycle long or short. It reads a register in the first busy cycle and again after busy falls, on two instances with opposite commit modes. Committing at the wrong edge shows up as a new value too early or a stale one too late. A single copy is followed by a wiper change inside the window, which catches a design that samples the wiper at commit instead of at the request. A request is sent into a running window and a request is sent under write protect. A design that lets either through would change a register, stretch the window, or raise busy.

// File: rtl/nvs_pkg.sv
// Shared types for the nonvolatile store sequencer.
// Assumes the request kind arrives on a 2-bit field.
package nvs_pkg;

    typedef enum logic [1:0] {
        KIND_HOST_WRITE = 2'd0,
        KIND_COPY_ONE   = 2'd1,
        KIND_COPY_ALL   = 2'd2,
        KIND_NONE       = 2'd3
    } store_kind_e;

    // Status byte seen by the serial front end: only the low bit is live.
    function automatic logic [7:0] make_status(input logic busy_bit);
        return {7'b000_0000, busy_bit};
    endfunction

endpackage

// File: rtl/nvs_busy_timer.sv
// Busy window timer. A start pulse loads BUSY_CYCLES. Busy is high while the
// count is nonzero. Last marks the final busy cycle.
// Assumes start never arrives while busy (the request gate guarantees it).
module nvs_busy_timer #(
    parameter int BUSY_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] count_q;

    // Load on start, count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (start) begin
            count_q <= CW'(BUSY_CYCLES);
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign busy = (count_q != '0);
    assign last = (count_q == CW'(1));

    // Independent length checker: counts consecutive busy cycles.
    logic [CW:0] chk_len_q;

    // Run-length counter for the window-length assertion.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_len_q <= '0;
        else        chk_len_q <= busy ? chk_len_q + 1'b1 : '0;
    end

    p_window_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (chk_len_q == (CW+1)'(BUSY_CYCLES)));

    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);

endmodule

// File: rtl/nvs_req_gate.sv
// Request gate. It sorts each store request into accept, write-protect block,
// busy reject, or ignore. For an accepted request it builds the per-pot write
// mask and write data and keeps a latched copy for a commit at window end.
// Assumes requests are single-cycle strobes.
module nvs_req_gate
    import nvs_pkg::*;
#(
    parameter int NPOT = 2,
    parameter int NREG = 4,
    parameter int W    = 8,
    parameter int PW   = 1,
    parameter int RW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wp_n,
    input  logic            busy,
    input  logic            req_valid,
    input  store_kind_e     req_kind,
    input  logic [PW-1:0]   req_pot,
    input  logic [RW-1:0]   req_reg,
    input  logic [W-1:0]    req_data,
    input  logic [NPOT*W-1:0] wiper_flat,
    output logic            start,
    output logic [NPOT-1:0] now_mask,
    output logic [RW-1:0]   now_reg,
    output logic [NPOT*W-1:0] now_data,
    output logic [NPOT-1:0] held_mask,
    output logic [RW-1:0]   held_reg,
    output logic [NPOT*W-1:0] held_data,
    output logic            accept_q,
    output logic            blocked_q,
    output logic            reject_q
);
    logic live_req;

    assign live_req = req_valid && (req_kind != KIND_NONE);
    assign start    = live_req && !busy && wp_n;
    assign now_reg  = req_reg;

    // Per-pot mask and data for the request on the inputs.
    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        always_comb begin : c_pot_sel
            now_mask[p] = (req_kind == KIND_COPY_ALL) ||
                          ((req_kind != KIND_NONE) && (req_pot == PW'(p)));
            now_data[p*W +: W] = (req_kind == KIND_HOST_WRITE) ? req_data
                                                               : wiper_flat[p*W +: W];
        end
    end

    // Outcome pulses and sticky reject flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_q  <= 1'b0;
            blocked_q <= 1'b0;
            reject_q  <= 1'b0;
        end else begin
            accept_q  <= start;
            blocked_q <= live_req && !busy && !wp_n;
            if (live_req && busy) reject_q <= 1'b1;
        end
    end

    // Latch the accepted store for a deferred commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_mask <= '0;
            held_reg  <= '0;
            held_data <= '0;
        end else if (start) begin
            held_mask <= now_mask;
            held_reg  <= now_reg;
            held_data <= now_data;
        end
    end

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_req && busy) |=> reject_q);

    p_wp_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_req && !wp_n) |=> !accept_q);

endmodule

// File: rtl/nvs_data_array.sv
// Data register array: NREG registers of W bits per pot. A write updates the
// registers at index wr_reg in every pot whose mask bit is set.
// Assumes rd_pot and rd_reg are within range. Out-of-range reads return 0.
module nvs_data_array #(
    parameter int NPOT = 2,
    parameter int NREG = 4,
    parameter int W    = 8,
    parameter int PW   = 1,
    parameter int RW   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NPOT-1:0]   wr_mask,
    input  logic [RW-1:0]     wr_reg,
    input  logic [NPOT*W-1:0] wr_data,
    input  logic [PW-1:0]     rd_pot,
    input  logic [RW-1:0]     rd_reg,
    output logic [W-1:0]      rd_data
);
    logic [W-1:0] mem_q [NPOT][NREG];

    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            // Storage cell for pot p, register r.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem_q[p][r] <= '0;
                end else if (wr_en && wr_mask[p] && (wr_reg == RW'(r))) begin
                    mem_q[p][r] <= wr_data[p*W +: W];
                end
            end
        end
    end

    // Read mux with range guard.
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NPOT; p++) begin
            for (int r = 0; r < NREG; r++) begin
                if ((rd_pot == PW'(p)) && (rd_reg == RW'(r))) rd_data = mem_q[p][r];
            end
        end
    end

endmodule

// File: rtl/nvs_store_seq.sv
// Nonvolatile store sequencer top. It joins the request gate, busy timer and
// data array. COMMIT_AT_END picks whether the write lands on the first or the
// last edge of the busy window. Assumes wiper values are stable in the request
// cycle.
module nvs_store_seq
    import nvs_pkg::*;
#(
    parameter int NPOT          = 2,
    parameter int NREG          = 4,
    parameter int W             = 8,
    parameter int BUSY_CYCLES   = 50,
    parameter bit COMMIT_AT_END = 1'b1,
    localparam int PW = (NPOT > 1) ? $clog2(NPOT) : 1,
    localparam int RW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [PW-1:0]     req_pot,
    input  logic [RW-1:0]     req_reg,
    input  logic [W-1:0]      req_data,
    input  logic [NPOT*W-1:0] wiper_flat,
    input  logic [PW-1:0]     rd_pot,
    input  logic [RW-1:0]     rd_reg,
    output logic [W-1:0]      rd_data,
    output logic              busy,
    output logic [7:0]        status_byte,
    output logic              store_accepted,
    output logic              store_blocked,
    output logic              reject_seen
);
    logic              start, last;
    logic [NPOT-1:0]   now_mask, held_mask, wr_mask;
    logic [RW-1:0]     now_reg, held_reg, wr_reg;
    logic [NPOT*W-1:0] now_data, held_data, wr_data;
    logic              wr_en;

    nvs_req_gate #(.NPOT(NPOT), .NREG(NREG), .W(W), .PW(PW), .RW(RW)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wp_n      (wp_n),
        .busy      (busy),
        .req_valid (req_valid),
        .req_kind  (store_kind_e'(req_kind)),
        .req_pot   (req_pot),
        .req_reg   (req_reg),
        .req_data  (req_data),
        .wiper_flat(wiper_flat),
        .start     (start),
        .now_mask  (now_mask),
        .now_reg   (now_reg),
        .now_data  (now_data),
        .held_mask (held_mask),
        .held_reg  (held_reg),
        .held_data (held_data),
        .accept_q  (store_accepted),
        .blocked_q (store_blocked),
        .reject_q  (reject_seen)
    );

    nvs_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .busy (busy),
        .last (last)
    );

    if (COMMIT_AT_END) begin : g_late
        // Commit the latched store on the final busy edge.
        always_comb begin
            wr_en   = last;
            wr_mask = held_mask;
            wr_reg  = held_reg;
            wr_data = held_data;
        end
    end else begin : g_early
        // Commit the incoming store on the accepting edge.
        always_comb begin
            wr_en   = start;
            wr_mask = now_mask;
            wr_reg  = now_reg;
            wr_data = now_data;
        end
    end

    nvs_data_array #(.NPOT(NPOT), .NREG(NREG), .W(W), .PW(PW), .RW(RW)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_mask(wr_mask),
        .wr_reg (wr_reg),
        .wr_data(wr_data),
        .rd_pot (rd_pot),
        .rd_reg (rd_reg),
        .rd_data(rd_data)
    );

    assign status_byte = make_status(busy);

    p_rise_with_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> store_accepted);

    p_rise_needs_wp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wp_n));

    p_write_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (COMMIT_AT_END ? busy : !busy));

    p_status_low_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[0] == busy);

endmodule

// File: tb/tb_nvs_store_seq.sv
// Directed bench. Two instances see the same stimulus: dut commits at window
// end, dut_early commits at window start.
module tb_nvs_store_seq;
    localparam int NPOT = 2, NREG = 4, W = 8, N = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_n = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic req_pot = 1'b0;
    logic [1:0] req_reg = '0;
    logic [W-1:0] req_data = '0;
    logic [NPOT*W-1:0] wiper_flat = '0;
    logic rd_pot = 1'b0;
    logic [1:0] rd_reg = '0;

    logic [W-1:0] rd_data, e_rd_data;
    logic busy, e_busy, acc, e_acc, blk, e_blk, rej, e_rej;
    logic [7:0] status, e_status;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    nvs_store_seq #(.NPOT(NPOT), .NREG(NREG), .W(W), .BUSY_CYCLES(N), .COMMIT_AT_END(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_pot(req_pot), .req_reg(req_reg), .req_data(req_data), .wiper_flat(wiper_flat),
        .rd_pot(rd_pot), .rd_reg(rd_reg), .rd_data(rd_data), .busy(busy), .status_byte(status),
        .store_accepted(acc), .store_blocked(blk), .reject_seen(rej));

    nvs_store_seq #(.NPOT(NPOT), .NREG(NREG), .W(W), .BUSY_CYCLES(N), .COMMIT_AT_END(1'b0)) dut_early (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_pot(req_pot), .req_reg(req_reg), .req_data(req_data), .wiper_flat(wiper_flat),
        .rd_pot(rd_pot), .rd_reg(rd_reg), .rd_data(e_rd_data), .busy(e_busy), .status_byte(e_status),
        .store_accepted(e_acc), .store_blocked(e_blk), .reject_seen(e_rej));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    // Drive one request for one cycle. Returns at the first cycle after it.
    task automatic send(input logic [1:0] k, input logic p, input logic [1:0] r, input logic [W-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_pot = p; req_reg = r; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Called in the first busy cycle: checks busy length and commit timing on the read port.
    task automatic run_window(input string tag, input logic [W-1:0] old_v, input logic [W-1:0] new_v);
        int cnt = 0;
        eq({tag, " R10 accept pulse"}, acc, 1);
        eq({tag, " R9 status busy"}, status, 8'h01);
        eq({tag, " R8 late still old"}, rd_data, old_v);
        eq({tag, " R8 early already new"}, e_rd_data, new_v);
        while (busy && cnt < 4 * N) begin
            cnt++;
            @(negedge clk);
            if (cnt == 1) eq({tag, " R10 single pulse"}, acc, 0);
        end
        eq({tag, " R2 busy length"}, cnt, N);
        eq({tag, " R8 late new after fall"}, rd_data, new_v);
        eq({tag, " R9 status idle"}, status, 8'h00);
    endtask

    task automatic t_reset();
        eq("R1 busy", busy, 0);
        eq("R1 status", status, 0);
        eq("R1 flags", {acc, blk, rej, e_rej}, 0);
        for (int p = 0; p < NPOT; p++) begin
            for (int r = 0; r < NREG; r++) begin
                rd_pot = p[0]; rd_reg = r[1:0];
                #0.1;
                eq("R1 register zero", rd_data, 0);
                eq("R1 register zero early", e_rd_data, 0);
            end
        end
    endtask

    task automatic t_host_write();
        rd_pot = 1'b1; rd_reg = 2'd2;
        send(2'd0, 1'b1, 2'd2, 8'hA5);
        run_window("R3 host write", 8'h00, 8'hA5);
        rd_pot = 1'b0; #0.1;
        eq("R3 other pot untouched", rd_data, 0);
        rd_pot = 1'b1; rd_reg = 2'd1; #0.1;
        eq("R3 other reg untouched", rd_data, 0);
    endtask

    task automatic t_copy_one();
        wiper_flat = {8'hC3, 8'h3C};
        rd_pot = 1'b0; rd_reg = 2'd3;
        send(2'd1, 1'b0, 2'd3, 8'hEE);
        wiper_flat = 16'h0000;
        run_window("R4 single copy", 8'h00, 8'h3C);
        rd_pot = 1'b1; #0.1;
        eq("R4 other pot untouched", rd_data, 0);
    endtask

    task automatic t_copy_all();
        wiper_flat = {8'h22, 8'h11};
        rd_pot = 1'b0; rd_reg = 2'd1;
        send(2'd2, 1'b1, 2'd1, 8'h00);
        run_window("R5 global copy pot0", 8'h00, 8'h11);
        rd_pot = 1'b1; #0.1;
        eq("R5 global copy pot1", rd_data, 8'h22);
        eq("R5 global copy pot1 early", e_rd_data, 8'h22);
    endtask

    task automatic t_protect();
        wp_n = 1'b0;
        rd_pot = 1'b0; rd_reg = 2'd0;
        send(2'd0, 1'b0, 2'd0, 8'hFF);
        eq("R6 blocked pulse", blk, 1);
        eq("R6 no busy", busy, 0);
        eq("R6 no accept", acc, 0);
        repeat (N + 2) @(negedge clk);
        eq("R6 register kept", rd_data, 0);
        eq("R6 register kept early", e_rd_data, 0);
        eq("R6 pulse ends", blk, 0);
        wp_n = 1'b1;
    endtask

    task automatic t_busy_reject();
        int cnt = 0;
        rd_pot = 1'b1; rd_reg = 2'd0;
        send(2'd0, 1'b0, 2'd0, 8'h77);
        eq("R7 no sticky before", rej, 0);
        repeat (3) @(negedge clk);
        cnt = 3;
        req_valid = 1'b1; req_kind = 2'd0; req_pot = 1'b1; req_reg = 2'd0; req_data = 8'h99;
        @(negedge clk);
        req_valid = 1'b0;
        cnt++;
        eq("R7 sticky set", rej, 1);
        while (busy && cnt < 4 * N) begin
            cnt++;
            @(negedge clk);
        end
        eq("R7 window length kept", cnt, N);
        eq("R7 dropped write", rd_data, 0);
        eq("R7 dropped write early", e_rd_data, 0);
        rd_pot = 1'b0; #0.1;
        eq("R7 first store done", rd_data, 8'h77);
        repeat (5) @(negedge clk);
        eq("R7 sticky holds", rej, 1);
        eq("R7 no restart", busy, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_host_write();
        t_copy_one();
        t_copy_all();
        t_protect();
        t_busy_reject();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule